// File: doc/BRIEF.md
# First-in first-out buffer with read rewind and occupancy flags

This block is a single-clock first-in first-out store for 9-bit words, with a depth of 1024, 2048 or 4096 entries set by a parameter. Producers pulse an active-low write strobe and consumers pulse an active-low read strobe. Each strobe is sampled on the rising clock edge, and at most one word moves on each side per cycle. Four active-low flags report the fill level: full, empty, more than half full, and a combined near-empty/near-full flag. The flags follow a registered occupancy counter, so each flag changes in the cycle after the edge that moved a word.

An active-low rewind input sends the read side back to the first storage location. The data can then be replayed, as long as no more than one buffer's worth has been written since reset. The output side has a valid qualifier in place of a three-state pad. Data is presented only while a read strobe and the active-low output enable are both asserted and the buffer holds something. With the output enable inactive, a read still consumes a word but nothing is shown.

Top module: `fifo_rt`

## Requirements
- R1: While rst_n is low at a rising edge, both pointers return to location 0 and the occupancy goes to zero. From then on full_n=1, half_n=1, empty_n=0, almost_n=0 and dout_vld=0.
- R2: With wr_n low at an edge and the occupancy below DEPTH, din is stored and the occupancy rises by one. full_n is 0 exactly when the occupancy equals DEPTH.
- R3: With wr_n low at an edge while full, nothing is stored and the write pointer holds, so the words already stored come out unchanged.
- R4: With rd_n low at an edge and the occupancy above zero, the oldest word is consumed. Words leave in the order they were written. empty_n is 0 exactly when the occupancy is zero.
- R5: With rd_n low at an edge while empty, the read pointer holds, and the next word written is the next word read.
- R6: If both strobes are low in the same cycle, the occupancy is unchanged when the buffer is partly filled. When full, only the read takes effect. When empty, only the write takes effect.
- R7: half_n is 0 exactly when the occupancy is greater than DEPTH/2.
- R8: almost_n is 0 when the occupancy is at most DEPTH/8 or at least DEPTH-DEPTH/8, and 1 strictly between those two levels.
- R9: With rt_n low and both strobes high at an edge, the read pointer returns to location 0 and the write pointer holds. The occupancy becomes the number of words written since reset (valid when that number is at most DEPTH).
- R10: With rt_n low while either strobe is low, the rewind is ignored, and that strobe acts as normal.
- R11: While oe_n is high, dout_vld stays 0 and dout stays 0, but a read still consumes a word.
- R12: dout_vld is 1 exactly when rd_n=0, oe_n=0 and empty_n=1. dout then shows the oldest stored word; otherwise dout is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which strobes are sampled |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Read-side rewind, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | WIDTH | Word to store |
| dout | output | WIDTH | Oldest word when dout_vld is 1, else zero |
| dout_vld | output | 1 | Output data qualifier |
| full_n | output | 1 | Low when DEPTH words are held |
| empty_n | output | 1 | Low when no word is held |
| half_n | output | 1 | Low above DEPTH/2 words |
| almost_n | output | 1 | Low near empty or near full |

## Verification
The bench uses a 16-deep instance, so every flag threshold is crossed in both directions, and it compares each cycle against an arithmetic model. It goes after writes into a full buffer and reads from an empty one. A design that let either pointer move there would return stale or overwritten words later in the read sequence. Simultaneous strobes at full and at empty catch a counter that adds and subtracts blindly and leaves the flags off by one. The rewind is tried alone and with each strobe active: a rewind accepted during a read would replay word 0 when the next word is due. Reads with the output enable inactive must still advance, or the following word comes out twice.

// File: rtl/fifo_rt_pkg.sv
// Package: shared types and helpers for the rewindable FIFO.
// Assumes depths are powers of two so pointers wrap naturally.
package fifo_rt_pkg;

    // Decoded per-cycle request set, active high.
    typedef struct packed {
        logic wr;
        logic rd;
        logic rt;
    } fifo_req_t;

endpackage

// File: rtl/fifo_rt_store.sv
// Module: storage array with one synchronous write port and one
// combinational read port. Assumes DEPTH is a power of two; no reset
// on the array contents.
module fifo_rt_store #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store an accepted word at the write location.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the word at the read location without delay.
    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/fifo_rt_ctrl.sv
// Module: pointer and occupancy control. It accepts a write only below
// DEPTH and a read only above zero, and accepts a rewind only with
// no strobe active. The write pointer carries one extra wrap bit so
// the rewind can rebuild the occupancy. Synchronous active-low reset.
module fifo_rt_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_req_t     req,
    output logic          wr_fire,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] wr_ptr_ext,
    output logic [CW-1:0] occ
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic          rd_fire;
    logic          rt_fire;
    logic [CW-1:0] replay_lvl;

    // Decide which requests take effect this cycle.
    always_comb begin
        wr_fire = req.wr && (occ != FULL_LVL);
        rd_fire = req.rd && (occ != '0);
        rt_fire = req.rt && !req.wr && !req.rd;
    end

    // Occupancy after a rewind: the words written since reset, saturated.
    always_comb begin
        if (wr_ptr_ext[AW]) begin
            replay_lvl = FULL_LVL;
        end else begin
            replay_lvl = wr_ptr_ext;
        end
    end

    // Advance the write pointer on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_ext <= '0;
        end else if (wr_fire) begin
            wr_ptr_ext <= wr_ptr_ext + 1'b1;
        end
    end

    // Advance or rewind the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rt_fire) begin
            rd_ptr <= '0;
        end else if (rd_fire) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Track how many words are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else if (rt_fire) begin
            occ <= replay_lvl;
        end else if (wr_fire && !rd_fire) begin
            occ <= occ + 1'b1;
        end else if (rd_fire && !wr_fire) begin
            occ <= occ - 1'b1;
        end
    end

endmodule

// File: rtl/fifo_rt_flags.sv
// Module: status flag decode from the occupancy count. All flags are
// active low. Assumes DEPTH is a power of two of at least 8.
module fifo_rt_flags #(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] occ,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_n,
    output logic          almost_n
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LOW_LVL  = CW'(DEPTH / 8);
    localparam logic [CW-1:0] HIGH_LVL = CW'(DEPTH - DEPTH / 8);

    // Compare the count against each threshold.
    always_comb begin
        full_n   = (occ != FULL_LVL);
        empty_n  = (occ != '0);
        half_n   = !(occ > HALF_LVL);
        almost_n = (occ > LOW_LVL) && (occ < HIGH_LVL);
    end

endmodule

// File: rtl/fifo_rt.sv
// Module: top of the rewindable FIFO. It turns the active-low strobes
// into requests, ties storage, control and flags together, and gates
// the output with read and output enable. Assumes one clock domain,
// strobes sampled on the rising edge, synchronous active-low reset.
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_vld,
    output logic             full_n,
    output logic             empty_n,
    output logic             half_n,
    output logic             almost_n
);

    fifo_req_t        req;
    logic             wr_fire;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    wr_ptr_ext;
    logic [CW-1:0]    occ;
    logic [WIDTH-1:0] rdata;

    // Convert the active-low pins to a request set.
    always_comb begin
        req.wr = !wr_n;
        req.rd = !rd_n;
        req.rt = !rt_n;
    end

    fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .wr_fire    (wr_fire),
        .rd_ptr     (rd_ptr),
        .wr_ptr_ext (wr_ptr_ext),
        .occ        (occ)
    );

    fifo_rt_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_ptr_ext[AW-1:0]),
        .wdata (din),
        .raddr (rd_ptr),
        .rdata (rdata)
    );

    fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
        .occ      (occ),
        .full_n   (full_n),
        .empty_n  (empty_n),
        .half_n   (half_n),
        .almost_n (almost_n)
    );

    // Show the head word only for an enabled read of a non-empty buffer.
    always_comb begin
        dout_vld = req.rd && !oe_n && empty_n;
        dout     = dout_vld ? rdata : '0;
    end

endmodule

// File: rtl/fifo_rt_chk.sv
// Module: property checker for fifo_rt, attached by bind. It watches
// the pins and the pointer and occupancy state.
module fifo_rt_chk #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_n,
    input logic          rd_n,
    input logic          rt_n,
    input logic          oe_n,
    input logic          dout_vld,
    input logic          full_n,
    input logic          empty_n,
    input logic [AW-1:0] rd_ptr,
    input logic [CW-1:0] wr_ptr,
    input logic [CW-1:0] occ
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (occ == '0 && rd_ptr == '0 && wr_ptr == '0));

    // R3
    full_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !wr_n) |=> $stable(wr_ptr));

    // R5
    empty_read_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rd_n) |=> $stable(rd_ptr));

    // R6
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_n || !rd_n || !wr_n) |=>
        (occ == $past(occ) || occ == $past(occ) + 1'b1 || occ + 1'b1 == $past(occ)));

    // R9
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_n && rd_n && wr_n) |=> (rd_ptr == '0 && $stable(wr_ptr)));

    // R10
    rewind_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_n && !wr_n && rd_n) |=> $stable(rd_ptr));

    // R12
    output_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> (!rd_n && !oe_n && empty_n));

endmodule

bind fifo_rt fifo_rt_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .rt_n     (rt_n),
    .oe_n     (oe_n),
    .dout_vld (dout_vld),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .rd_ptr   (rd_ptr),
    .wr_ptr   (wr_ptr_ext),
    .occ      (occ)
);

// File: tb/fifo_rt_tb.sv
// Bench: 16-deep instance, directed corner cases plus biased sweeps,
// compared each cycle against an arithmetic model of the requirements.
module fifo_rt_tb;

    localparam int PERIOD = 10;
    localparam int D      = 16;
    localparam int W      = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         rt_n = 1'b1;
    logic         oe_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         dout_vld;
    logic         full_n;
    logic         empty_n;
    logic         half_n;
    logic         almost_n;

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    int rp = 0;
    int wp = 0;
    int wtot = 0;
    logic [W-1:0] mdl [D];
    logic [15:0]  lfsr = 16'hACE1;

    always #(PERIOD/2) clk = ~clk;

    fifo_rt #(.DEPTH(D), .WIDTH(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .rt_n     (rt_n),
        .oe_n     (oe_n),
        .din      (din),
        .dout     (dout),
        .dout_vld (dout_vld),
        .full_n   (full_n),
        .empty_n  (empty_n),
        .half_n   (half_n),
        .almost_n (almost_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_flags();
        check(full_n == (cnt != D), "R2 full_n", full_n, cnt != D);
        check(empty_n == (cnt != 0), "R4 empty_n", empty_n, cnt != 0);
        check(half_n == !(cnt > D/2), "R7 half_n", half_n, !(cnt > D/2));
        check(almost_n == ((cnt > D/8) && (cnt < D - D/8)), "R8 almost_n",
              almost_n, (cnt > D/8) && (cnt < D - D/8));
    endtask

    // One cycle: drive, check output before the edge, update model, check flags.
    task automatic step(input bit w, input bit r, input bit t, input bit o,
                        input logic [W-1:0] d, input string tag);
        bit ev;
        bit wacc;
        bit racc;
        bit tacc;
        wr_n = !w; rd_n = !r; rt_n = !t; oe_n = !o; din = d;
        #1;
        ev = r && o && (cnt > 0);
        check(dout_vld == ev, {tag, " dout_vld"}, dout_vld, ev);
        if (ev) check(dout == mdl[rp], {tag, " dout"}, dout, mdl[rp]);
        else    check(dout == '0, {tag, " dout idle"}, dout, 0);
        @(posedge clk);
        #(PERIOD/4);
        wacc = w && (cnt < D);
        racc = r && (cnt > 0);
        tacc = t && !w && !r;
        if (racc) rp = (rp + 1) % D;
        if (wacc) begin mdl[wp] = d; wp = (wp + 1) % D; wtot++; end
        if (tacc) begin rp = 0; cnt = (wtot > D) ? D : wtot; end
        else cnt = cnt + int'(wacc) - int'(racc);
        check_flags();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; oe_n = 1'b1;
        @(posedge clk); @(posedge clk);
        #(PERIOD/4);
        cnt = 0; rp = 0; wp = 0; wtot = 0;
        // R1: flags and output after reset
        check(full_n == 1'b1, "R1 full_n", full_n, 1);
        check(half_n == 1'b1, "R1 half_n", half_n, 1);
        check(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
        check(almost_n == 1'b0, "R1 almost_n", almost_n, 0);
        check(dout_vld == 1'b0, "R1 dout_vld", dout_vld, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R2: fill through every level
        for (int i = 0; i < D; i++) step(1, 0, 0, 0, W'(i * 37 + 5), "R2");
        // R3: writes into a full buffer
        step(1, 0, 0, 0, 9'h1AA, "R3");
        step(1, 0, 0, 1, 9'h155, "R3");
        // R6: both strobes while full, only the read counts
        step(1, 1, 0, 1, 9'h0F0, "R6 full");
        // R4 and R11: drain, some reads with output disabled
        for (int i = 0; i < D - 1; i++) step(0, 1, 0, (i % 3) != 1, '0, "R11");
        // R5: reads from empty
        step(0, 1, 0, 1, '0, "R5");
        step(0, 1, 0, 0, '0, "R5");
        // R6: both strobes while empty, only the write counts
        step(1, 1, 0, 1, 9'h077, "R6 empty");
        step(0, 1, 0, 1, '0, "R5 next");
        // R6: partly filled, both strobes
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, W'(i + 100), "R6");
        for (int i = 0; i < 6; i++) step(1, 1, 0, 1, W'(i + 200), "R6 mid");
        // R12: output enable without a read shows nothing
        step(0, 0, 0, 1, '0, "R12");

        // R9 and R10: rewind
        do_reset();
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, W'(i * 11 + 3), "R9 load");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, '0, "R9 read");
        step(0, 1, 1, 1, '0, "R10 rd");
        step(1, 0, 1, 0, 9'h1E1, "R10 wr");
        step(0, 0, 1, 0, '0, "R9");
        for (int i = 0; i < 12; i++) step(0, 1, 0, 1, '0, "R9 replay");

        // Biased sweeps over every fill level
        do_reset();
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 400; i++) begin
                bit w;
                bit r;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                w = (ph % 2 == 0) ? (lfsr[0] | lfsr[1]) : (lfsr[0] & lfsr[1]);
                r = (ph % 2 == 0) ? (lfsr[2] & lfsr[3]) : (lfsr[2] | lfsr[3]);
                step(w, r, 0, lfsr[4] | lfsr[5], W'(lfsr[12:4]), "R4 sweep");
            end
        end
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule